// File: doc/BRIEF.md
# Receive Clock Source Selector

This block chooses where the receive-side clock of a media-independent interface comes from: the clock recovered from the incoming line, or the local transmit clock. The decision follows line activity and link speed. A carrier on the receive pair asks for the recovered clock. With no carrier, a 10 Mbit/s link falls back to the transmit clock, because that line goes quiet when idle. A 100 Mbit/s link keeps the recovered clock, because idle symbols keep arriving on the line.

A change of source is allowed only while receive-data-valid is low. While valid is high, the source in use is held. The carrier, valid and speed inputs are brought into the transmit-clock domain through synchronisers, and the decision is registered there. The output clock comes from a glitch-free switch built from one enable per source. Each enable is synchronised in its own source clock and changes on that clock's falling edge. An enable turns on only after the other enable is seen off. Receive data, valid and error are registered on the rising edge of the switched clock. After reset the transmit clock is selected.

Top module: `rx_clk_src_sel`

## Requirements
- R1: With `rx_dv_in` low and `carrier_in` high, `src_rec_out` becomes 1 (recovered clock) on the third rising `tx_clk` edge after the inputs change, and not earlier.
- R2: While the synchronised `rx_dv_in` is high, `src_rec_out` keeps its value whatever `carrier_in` and `speed_100_in` do.
- R3: With `rx_dv_in` low, `carrier_in` low and `speed_100_in` low (10 Mbit/s), `src_rec_out` becomes 0 (transmit clock) on the third rising `tx_clk` edge.
- R4: With `rx_dv_in` low and `speed_100_in` high (100 Mbit/s), `src_rec_out` becomes 1 on the third rising `tx_clk` edge, whether or not a carrier is present.
- R5: During and after reset `src_rec_out` is 0, and `rx_clk_out` follows `tx_clk`.
- R6: The two source enables are never on together. Once a switch has settled, `rx_clk_out` equals the selected source clock.
- R7: `rxd_out`, `rx_dv_out` and `rx_err_out` take the values that `rxd_in`, `rx_dv_in` and `rx_err_in` hold at a rising edge of `rx_clk_out`, and present them right after that edge.
- R8: While `rst` is high, `rxd_out`, `rx_dv_out` and `rx_err_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Local transmit clock; clocks the selection logic |
| rec_clk | input | 1 | Clock recovered from the receive line |
| rst | input | 1 | Synchronous active-high reset |
| carrier_in | input | 1 | Carrier present on the receive pair |
| rx_dv_in | input | 1 | Receive data valid |
| speed_100_in | input | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| rxd_in | input | DATA_W | Receive data nibble |
| rx_err_in | input | 1 | Receive error |
| rx_clk_out | output | 1 | Switched receive clock |
| rxd_out | output | DATA_W | Receive data retimed to rx_clk_out |
| rx_dv_out | output | 1 | Data valid retimed to rx_clk_out |
| rx_err_out | output | 1 | Error retimed to rx_clk_out |
| src_rec_out | output | 1 | Registered source: 1 = recovered, 0 = transmit |

## Verification
The bench changes the line inputs on a falling `tx_clk` edge. The source indication is due on the third rising `tx_clk` edge after that change, so the scoreboard checks the old value at the second falling edge and the new value at the third. Retimed beats are driven on a falling edge of `rx_clk_out` and compared half a nanosecond after the next rising edge. The output clock is compared with the expected source only after sixteen `tx_clk` cycles of settling. Those comparisons are taken at half-nanosecond offsets, where neither source clock has an edge.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;

    typedef enum logic {
        SRC_TX  = 1'b0,
        SRC_REC = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic carrier;
        logic dv;
        logic fast;
    } line_state_t;

    localparam int NUM_SRC = 2;

    function automatic clk_src_e idle_source(line_state_t s);
        return (s.carrier || s.fast) ? SRC_REC : SRC_TX;
    endfunction

    function automatic clk_src_e next_source(clk_src_e cur, line_state_t s);
        return s.dv ? cur : idle_source(s);
    endfunction

endpackage

// File: rtl/rcs_sync.sv
`timescale 1ns/1ps
module rcs_sync #(
    parameter int W = 1,
    parameter int DEPTH = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/rcs_policy.sv
`timescale 1ns/1ps
module rcs_policy
    import rcs_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  line_state_t line_raw,
    output clk_src_e    src_q
);
    localparam int LW = $bits(line_state_t);

    logic [LW-1:0] raw_v;
    logic [LW-1:0] sync_v;
    line_state_t   line_s;

    assign raw_v = line_raw;

    rcs_sync #(.W(LW), .DEPTH(SYNC_DEPTH)) u_line_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_v),
        .q   (sync_v)
    );

    assign line_s = line_state_t'(sync_v);

    always_ff @(posedge clk) begin
        if (rst) src_q <= SRC_TX;
        else     src_q <= next_source(src_q, line_s);
    end

    // R2: a valid frame pins the source
    p_hold_while_valid_r2: assert property (@(posedge clk) disable iff (rst)
        line_s.dv |=> src_q == $past(src_q));

    // R1: carrier with valid low moves to the recovered clock
    p_carrier_pick_rec_r1: assert property (@(posedge clk) disable iff (rst)
        (!line_s.dv && line_s.carrier) |=> src_q == SRC_REC);

    // R3: quiet 10 Mbit/s line uses the transmit clock
    p_quiet10_pick_tx_r3: assert property (@(posedge clk) disable iff (rst)
        (!line_s.dv && !line_s.carrier && !line_s.fast) |=> src_q == SRC_TX);

    // R4: idle 100 Mbit/s line keeps the recovered clock
    p_idle100_pick_rec_r4: assert property (@(posedge clk) disable iff (rst)
        (!line_s.dv && line_s.fast) |=> src_q == SRC_REC);
endmodule

// File: rtl/rcs_gate_stage.sv
`timescale 1ns/1ps
module rcs_gate_stage #(
    parameter logic RST_ON = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic en
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) meta <= RST_ON;
        else     meta <= req;
    end

    // enable moves only while its own clock is low
    always_ff @(negedge clk) begin
        if (rst) en <= RST_ON;
        else     en <= meta;
    end
endmodule

// File: rtl/rcs_retime.sv
`timescale 1ns/1ps
module rcs_retime #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d_in,
    input  logic              dv_in,
    input  logic              err_in,
    output logic [DATA_W-1:0] d_out,
    output logic              dv_out,
    output logic              err_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            d_out   <= '0;
            dv_out  <= 1'b0;
            err_out <= 1'b0;
        end else begin
            d_out   <= d_in;
            dv_out  <= dv_in;
            err_out <= err_in;
        end
    end

    // R7: outputs carry the previous edge's inputs
    p_retime_follow_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (d_out == $past(d_in)) && (dv_out == $past(dv_in))
                 && (err_out == $past(err_in)));
endmodule

// File: rtl/rx_clk_src_sel.sv
`timescale 1ns/1ps
module rx_clk_src_sel
    import rcs_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              tx_clk,
    input  logic              rec_clk,
    input  logic              rst,
    input  logic              carrier_in,
    input  logic              rx_dv_in,
    input  logic              speed_100_in,
    input  logic [DATA_W-1:0] rxd_in,
    input  logic              rx_err_in,
    output logic              rx_clk_out,
    output logic [DATA_W-1:0] rxd_out,
    output logic              rx_dv_out,
    output logic              rx_err_out,
    output logic              src_rec_out
);
    line_state_t        line_raw;
    clk_src_e           src_sel;
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] gate_en;

    assign line_raw = '{carrier: carrier_in, dv: rx_dv_in, fast: speed_100_in};

    rcs_policy #(.SYNC_DEPTH(SYNC_DEPTH)) u_policy (
        .clk      (tx_clk),
        .rst      (rst),
        .line_raw (line_raw),
        .src_q    (src_sel)
    );

    assign src_rec_out = (src_sel == SRC_REC);
    assign src_clk     = {rec_clk, tx_clk};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam clk_src_e OWN   = (g == 1) ? SRC_REC : SRC_TX;
        localparam logic     START = (OWN == SRC_TX) ? 1'b1 : 1'b0;
        logic req;
        assign req = (src_sel == OWN) && !gate_en[NUM_SRC-1-g];
        rcs_gate_stage #(.RST_ON(START)) u_gate (
            .clk (src_clk[g]),
            .rst (rst),
            .req (req),
            .en  (gate_en[g])
        );
    end

    assign rx_clk_out = |(src_clk & gate_en);

    rcs_retime #(.DATA_W(DATA_W)) u_retime (
        .clk     (rx_clk_out),
        .rst     (rst),
        .d_in    (rxd_in),
        .dv_in   (rx_dv_in),
        .err_in  (rx_err_in),
        .d_out   (rxd_out),
        .dv_out  (rx_dv_out),
        .err_out (rx_err_out)
    );

    // R6: break before make between the two source enables
    p_enables_exclusive_r6: assert property (@(posedge tx_clk) disable iff (rst)
        $onehot0(gate_en));
endmodule

// File: tb/sim_rx_clk_src_sel.sv
`timescale 1ns/1ps
module sim_rx_clk_src_sel;
    localparam int DW = 4;

    logic tx_clk = 1'b0, rec_clk = 1'b0, rst = 1'b1;
    logic carrier_in = 1'b0, rx_dv_in = 1'b0, speed_100_in = 1'b0, rx_err_in = 1'b0;
    logic [DW-1:0] rxd_in = '0;
    logic rx_clk_out, rx_dv_out, rx_err_out, src_rec_out;
    logic [DW-1:0] rxd_out;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic model_sel = 1'b0;

    typedef struct { int at; logic exp; string tag; } sel_item_t;
    typedef struct { logic [DW-1:0] d; logic dv; logic e; } beat_t;
    sel_item_t sq[$];
    beat_t     dq[$];

    always #2 tx_clk  = ~tx_clk;   // 250 MHz
    always #3 rec_clk = ~rec_clk;

    rx_clk_src_sel #(.DATA_W(DW)) u0 (
        .tx_clk, .rec_clk, .rst, .carrier_in, .rx_dv_in, .speed_100_in,
        .rxd_in, .rx_err_in, .rx_clk_out, .rxd_out, .rx_dv_out, .rx_err_out,
        .src_rec_out
    );

    always @(posedge tx_clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: source indication
    always @(negedge tx_clk) begin
        while (sq.size() > 0 && sq[0].at == cyc) begin
            sel_item_t it;
            it = sq.pop_front();
            check(it.tag, {31'd0, src_rec_out}, {31'd0, it.exp});
        end
    end

    // monitor: retimed beats
    always @(posedge rx_clk_out) begin : mon_data
        beat_t b;
        if (dq.size() > 0) begin
            b = dq.pop_front();
            #0.5;
            check("R7 data", {28'd0, rxd_out}, {28'd0, b.d});
            check("R7 valid/error", {30'd0, rx_dv_out, rx_err_out}, {30'd0, b.dv, b.e});
        end
    end

    task automatic set_line(input logic car, input logic dv, input logic fast, input string tag);
        logic nxt;
        @(negedge tx_clk);
        carrier_in = car; rx_dv_in = dv; speed_100_in = fast;
        nxt = dv ? model_sel : (car | fast);
        sq.push_back('{cyc + 2, model_sel, tag});
        sq.push_back('{cyc + 3, nxt, tag});
        model_sel = nxt;
        repeat (6) @(negedge tx_clk);
    endtask

    task automatic beat(input logic [DW-1:0] d, input logic e);
        @(negedge rx_clk_out);
        rxd_in = d; rx_err_in = e;
        dq.push_back('{d, rx_dv_in, e});
        @(posedge rx_clk_out);
        #1;
    endtask

    task automatic check_clock(input logic want_rec, input string tag);
        int bad = 0;
        @(posedge tx_clk);
        repeat (48) begin
            #0.5;
            if (rx_clk_out !== (want_rec ? rec_clk : tx_clk)) bad++;
            #0.5;
        end
        check(tag, bad, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #800000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rxd_in = 4'hF; rx_err_in = 1'b1; rx_dv_in = 1'b1;
        repeat (10) @(negedge tx_clk);
        check("R8 data in reset", {28'd0, rxd_out}, 32'd0);
        check("R8 flags in reset", {30'd0, rx_dv_out, rx_err_out}, 32'd0);
        check("R5 source in reset", {31'd0, src_rec_out}, 32'd0);
        rst = 1'b0; rx_dv_in = 1'b0; rxd_in = '0; rx_err_in = 1'b0;
        repeat (12) @(negedge tx_clk);
        check("R5 source after reset", {31'd0, src_rec_out}, 32'd0);
        check_clock(1'b0, "R5 clock follows tx");

        set_line(1'b1, 1'b0, 1'b0, "R1 carrier picks rec");
        repeat (16) @(negedge tx_clk);
        check_clock(1'b1, "R6 clock follows rec");

        set_line(1'b1, 1'b1, 1'b0, "R2 valid raised");
        beat(4'h3, 1'b0); beat(4'hA, 1'b1); beat(4'h5, 1'b0);
        beat(4'hC, 1'b0); beat(4'h0, 1'b1); beat(4'hF, 1'b0);
        set_line(1'b0, 1'b1, 1'b0, "R2 carrier drop held");
        check_clock(1'b1, "R2 clock held on rec");
        set_line(1'b0, 1'b0, 1'b0, "R3 quiet 10M picks tx");
        repeat (16) @(negedge tx_clk);
        check_clock(1'b0, "R6 clock back on tx");
        beat(4'h9, 1'b1); beat(4'h6, 1'b0); beat(4'h1, 1'b1); beat(4'hE, 1'b0);

        set_line(1'b0, 1'b0, 1'b1, "R4 idle 100M picks rec");
        repeat (16) @(negedge tx_clk);
        check_clock(1'b1, "R4 clock on rec");
        set_line(1'b0, 1'b1, 1'b1, "R2 valid at 100M");
        set_line(1'b0, 1'b1, 1'b0, "R2 speed change held");
        set_line(1'b0, 1'b0, 1'b0, "R3 release to tx");
        repeat (16) @(negedge tx_clk);
        check_clock(1'b0, "R3 clock on tx");
        set_line(1'b1, 1'b0, 1'b1, "R4 carrier at 100M");
        set_line(1'b0, 1'b0, 1'b1, "R4 no carrier at 100M");
        repeat (8) @(negedge tx_clk);
        check("R4 queue drained", sq.size(), 0);
        summary();
        $finish;
    end
endmodule